// File: doc/BRIEF.md
# Serial-Access Static Memory Target Controller

This block is the device side of an 8K x 8 static memory reached over a four-wire serial link (SPI mode 0 style). It runs on a fast system clock and samples the serial clock, select, data-in and pause pins through synchronizers. It finds serial clock edges from the synchronized samples. Each transaction starts with an 8-bit command and may carry a 16-bit address. Data then moves between the serial pins and a synchronous single-port RAM port, which sits outside the block.

An internal setup byte chooses how the address moves between consecutive data bytes. In single-byte mode only one byte moves. In page mode the address wraps inside a 32-byte page. In linear mode the address runs through the whole array and wraps at the top. The same byte can switch off the pause input. A host can pause a transfer in the middle by pulling the pause pin low while the serial clock is low. It picks up again at the same bit once the pin returns high during a clock-low phase. The serial output comes with a separate enable so that a pad can tri-state it.

Top module: `sram_serial_ctrl`

## Requirements
- R1: After reset `so_oe` is 0, and reading the setup byte returns 0x02: single-byte mode, pause enabled, bit 1 fixed at 1.
- R2: Command 0x03 is followed by 16 address bits, MSB first, of which only the low 13 are used. Data from that RAM address then leaves on `so` MSB first. Each bit changes after a falling serial clock edge. The first bit follows the falling edge after the last address bit.
- R3: Command 0x02 is followed by 16 address bits and then data bits sampled on rising edges, MSB first. Each full byte gives exactly one one-cycle `mem_wr` pulse carrying that address (low 13 bits) and that byte.
- R4: In single-byte mode (setup bits 7:6 = 00, and also 11) one data byte moves. After that, further serial clocks cause no RAM write and `so_oe` stays 0 until select rises.
- R5: In page mode (bits 7:6 = 10) the address after each byte increments bits 4:0 only, so 0x..1F is followed by 0x..00 of the same page.
- R6: In linear mode (bits 7:6 = 01) the address increments across page boundaries, and 0x1FFF is followed by 0x0000.
- R7: Command 0x01 stores the next byte: bits 7:6 are the mode and bit 0 is the pause-disable flag. Command 0x05 returns {mode, 0000, 1, pause-disable} MSB first.
- R8: Raising `cs_n` ends any transfer at once. `so_oe` drops, and an unfinished data byte is never written.
- R9: With pause enabled, `hold_n` low while `sck` is low freezes the transfer. `so_oe` is 0, and `sck` and `si` are ignored. Raising `hold_n` while `sck` is low resumes at the same bit.
- R10: With the pause-disable flag set, `hold_n` has no effect on the transfer.
- R11: A command other than 0x01, 0x02, 0x03 or 0x05 causes no RAM write and leaves `so_oe` at 0 until `cs_n` rises.
- R12: `hold_n` falling while `sck` is high takes effect only after the next falling `sck` edge. That edge still moves the output to the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low select pin |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause pin |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so` (0 means high-Z) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wr | output | 1 | RAM write strobe, one cycle |
| mem_wdata | output | 8 | RAM write data |
| mem_rd | output | 1 | RAM read strobe; data returns on the next cycle and is held |
| mem_rdata | input | 8 | RAM read data |

## Verification
The bench builds the block with its default values: a 13-bit address, a 5-bit page offset and two synchronizer stages. With these values the top-of-array wrap at 0x1FFF and the page wrap at offset 0x1F can be reached in a few bytes. The serial clock half-period is ten system cycles. This leaves room to assert and release the pause pin inside one clock phase, and to check `so_oe` between synchronizer settling and the next edge.

// File: rtl/sram_ser_pkg.sv
package sram_ser_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_WRST  = 8'h01;

  // value equals setup bits {7,6}
  typedef enum logic [1:0] {
    MODE_WORD  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PAGE  = 2'b10,
    MODE_RSVD  = 2'b11
  } seq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADR,
    ST_RDAT,
    ST_WDAT,
    ST_SRD,
    ST_SWR,
    ST_DEAD
  } ctl_state_e;

endpackage

// File: rtl/sram_bit_sync.sv
module sram_bit_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else if (g == 0) begin
          stage_q[g] <= d;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sram_addr_step.sv
module sram_addr_step
  import sram_ser_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic [AW-1:0] cur,
  input  seq_mode_e     mode,
  output logic [AW-1:0] nxt
);

  logic [AW-1:0] lin;
  assign lin = cur + 1'b1;

  generate
    if (PW < AW) begin : g_paged
      logic [AW-1:0] wrap;
      assign wrap = {cur[AW-1:PW], lin[PW-1:0]};
      assign nxt  = (mode == MODE_PAGE) ? wrap : lin;
    end else begin : g_flat
      assign nxt = lin;
    end
  endgenerate

endmodule

// File: rtl/sram_hold_gate.sv
module sram_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enable,
  input  logic hold_s,
  input  logic sck_s,
  output logic paused
);

  logic paused_n;

  always_comb begin
    paused_n = paused;
    if (!active) begin
      paused_n = 1'b0;
    end else if (paused) begin
      if (hold_s && !sck_s) paused_n = 1'b0;
    end else if (enable && !hold_s && !sck_s) begin
      paused_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused <= 1'b0;
    else        paused <= paused_n;
  end

endmodule

// File: rtl/sram_serial_ctrl.sv
module sram_serial_ctrl
  import sram_ser_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata
);

  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);

  // synchronized pins
  logic s_cs, s_hold, s_si, s_sck, sck_q;
  logic rise, fall, rise_v, fall_v, paused, active;

  sram_bit_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, hold_n, si, sck}),
    .q({s_cs, s_hold, s_si, s_sck})
  );

  // state
  ctl_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, step;
  logic [7:0]        osh_q, osh_n;
  logic              so_q, so_n, out_on_q, out_on_n, first_q, first_n;
  logic              is_rd_q, is_rd_n;
  seq_mode_e         mode_q, mode_n;
  logic              hold_dis_q, hold_dis_n;
  logic [ADDR_W-1:0] mem_addr_q, mem_addr_n;
  logic              mem_wr_q, mem_wr_n, mem_rd_q, mem_rd_n;
  logic [7:0]        mem_wdata_q, mem_wdata_n;

  logic [7:0]        byte_in, stat_byte, src_byte;
  logic [FRAME_W-1:0] frame_in;
  logic              word_m;

  assign rise     = s_sck & ~sck_q;
  assign fall     = ~s_sck & sck_q;
  assign rise_v   = rise & ~paused;
  assign fall_v   = fall & ~paused;
  assign active   = (state_q != ST_IDLE) & ~s_cs;
  assign byte_in  = {sh_q[6:0], s_si};
  assign frame_in = {sh_q[FRAME_W-2:0], s_si};
  assign stat_byte = {mode_q, 4'b0000, 1'b1, hold_dis_q};
  assign src_byte = (state_q == ST_SRD) ? stat_byte : mem_rdata;
  assign word_m   = (mode_q == MODE_WORD) || (mode_q == MODE_RSVD);

  sram_hold_gate i_hold (
    .clk(clk), .rst_n(rst_n), .active(active), .enable(~hold_dis_q),
    .hold_s(s_hold), .sck_s(s_sck), .paused(paused)
  );

  sram_addr_step #(.AW(ADDR_W), .PW(PAGE_W)) i_step (
    .cur(ptr_q), .mode(mode_q), .nxt(step)
  );

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    sh_n        = sh_q;
    ptr_n       = ptr_q;
    osh_n       = osh_q;
    so_n        = so_q;
    out_on_n    = out_on_q;
    first_n     = first_q;
    is_rd_n     = is_rd_q;
    mode_n      = mode_q;
    hold_dis_n  = hold_dis_q;
    mem_addr_n  = mem_addr_q;
    mem_wdata_n = mem_wdata_q;
    mem_wr_n    = 1'b0;
    mem_rd_n    = 1'b0;
    if (s_cs) begin
      state_n  = ST_IDLE;
      cnt_n    = '0;
      out_on_n = 1'b0;
      first_n  = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_CMD;
          cnt_n   = '0;
        end
        ST_CMD: if (rise_v) begin
          sh_n  = frame_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_n   = '0;
            first_n = 1'b1;
            unique case (byte_in)
              OP_READ:  begin state_n = ST_ADR; is_rd_n = 1'b1; end
              OP_WRITE: begin state_n = ST_ADR; is_rd_n = 1'b0; end
              OP_RDST:  state_n = ST_SRD;
              OP_WRST:  state_n = ST_SWR;
              default:  state_n = ST_DEAD;
            endcase
          end
        end
        ST_ADR: if (rise_v) begin
          sh_n  = frame_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == FRAME_LAST) begin
            cnt_n = '0;
            ptr_n = frame_in[ADDR_W-1:0];
            if (is_rd_q) begin
              state_n    = ST_RDAT;
              mem_addr_n = frame_in[ADDR_W-1:0];
              mem_rd_n   = 1'b1;
            end else begin
              state_n = ST_WDAT;
            end
          end
        end
        ST_RDAT, ST_SRD: if (fall_v) begin
          if (cnt_q == '0) begin
            if (!first_q && (word_m || state_q == ST_SRD)) begin
              state_n  = ST_DEAD;
              out_on_n = 1'b0;
            end else begin
              so_n     = src_byte[7];
              osh_n    = {src_byte[6:0], 1'b0};
              out_on_n = 1'b1;
              first_n  = 1'b0;
              cnt_n    = CNT_W'(1);
              if (state_q == ST_RDAT && !word_m) begin
                ptr_n      = step;
                mem_addr_n = step;
                mem_rd_n   = 1'b1;
              end
            end
          end else begin
            so_n  = osh_q[7];
            osh_n = {osh_q[6:0], 1'b0};
            cnt_n = (cnt_q == BYTE_LAST) ? '0 : cnt_q + 1'b1;
          end
        end
        ST_WDAT: if (rise_v) begin
          sh_n  = frame_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_n       = '0;
            mem_wr_n    = 1'b1;
            mem_addr_n  = ptr_q;
            mem_wdata_n = byte_in;
            ptr_n       = step;
            if (word_m) state_n = ST_DEAD;
          end
        end
        ST_SWR: if (rise_v) begin
          sh_n  = frame_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            mode_n     = seq_mode_e'(byte_in[7:6]);
            hold_dis_n = byte_in[0];
            state_n    = ST_DEAD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      osh_q       <= '0;
      so_q        <= 1'b0;
      out_on_q    <= 1'b0;
      first_q     <= 1'b1;
      is_rd_q     <= 1'b0;
      mode_q      <= MODE_WORD;
      hold_dis_q  <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      mem_wr_q    <= 1'b0;
      mem_rd_q    <= 1'b0;
      sck_q       <= 1'b0;
    end else begin
      state_q     <= state_n;
      cnt_q       <= cnt_n;
      sh_q        <= sh_n;
      ptr_q       <= ptr_n;
      osh_q       <= osh_n;
      so_q        <= so_n;
      out_on_q    <= out_on_n;
      first_q     <= first_n;
      is_rd_q     <= is_rd_n;
      mode_q      <= mode_n;
      hold_dis_q  <= hold_dis_n;
      mem_addr_q  <= mem_addr_n;
      mem_wdata_q <= mem_wdata_n;
      mem_wr_q    <= mem_wr_n;
      mem_rd_q    <= mem_rd_n;
      sck_q       <= s_sck;
    end
  end

  assign so        = so_q;
  assign so_oe     = out_on_q & ~paused & ((state_q == ST_RDAT) | (state_q == ST_SRD));
  assign mem_addr  = mem_addr_q;
  assign mem_wr    = mem_wr_q;
  assign mem_rd    = mem_rd_q;
  assign mem_wdata = mem_wdata_q;

endmodule

// File: rtl/sram_serial_ctrl_chk.sv
module sram_serial_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so_oe,
  input logic mem_wr,
  input logic mem_rd,
  input logic paused,
  input logic hold_dis
);

  logic [2:0] cs_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cs_hi <= '0;
    else if (!cs_n)                   cs_hi <= '0;
    else if (cs_hi != 3'd7)           cs_hi <= cs_hi + 3'd1;
  end

  // R8
  cs_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_hi >= 3'd4) |-> !so_oe);

  // R3
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(paused) && paused) |-> !mem_wr);

  // R10
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_dis |-> !paused);

endmodule

bind sram_serial_ctrl sram_serial_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .paused(paused), .hold_dis(hold_dis_q)
);

// File: tb/test_sram_serial_ctrl.sv
module test_sram_serial_ctrl;
  localparam int AW = 13;
  localparam int H  = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n;
  logic so, so_oe, mem_wr, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  sram_serial_ctrl i_sram_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  logic [7:0] ram [int];
  logic [7:0] refm [int];

  function automatic logic [7:0] dflt(int a);
    return 8'(a * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (mem_wr) ram[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : dflt(int'(mem_addr));
  end

  typedef struct { int a; logic [7:0] d; string tag; } wr_item_t;
  typedef struct { logic [7:0] d; string tag; } rd_item_t;
  wr_item_t   exp_wr[$];
  rd_item_t   exp_rd[$];
  logic [7:0] got_rd[$];
  int checks = 0, fails = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_rd(int a);
    return refm.exists(a) ? refm[a] : dflt(a);
  endfunction

  task automatic push_wr(int a, logic [7:0] d, string tag);
    exp_wr.push_back('{a, d, tag});
    refm[a] = d;
  endtask

  task automatic push_rd(logic [7:0] d, string tag);
    exp_rd.push_back('{d, tag});
  endtask

  // scoreboard monitors
  initial forever begin
    @(negedge clk);
    if (rst_n === 1'b1 && mem_wr === 1'b1) begin
      if (exp_wr.size() == 0) begin
        check(0, "R4 R8 R11", "unexpected write addr", int'(mem_addr), -1);
      end else begin
        wr_item_t it;
        it = exp_wr.pop_front();
        check(int'(mem_addr) == it.a && mem_wdata === it.d, it.tag, "write {addr,data}",
              {int'(mem_addr), 8'(mem_wdata)}, {it.a, 8'(it.d)});
      end
    end
    if (got_rd.size() > 0) begin
      logic [7:0] g;
      g = got_rd.pop_front();
      if (exp_rd.size() == 0) begin
        check(0, "R2", "unexpected read byte", int'(g), -1);
      end else begin
        rd_item_t e;
        e = exp_rd.pop_front();
        check(g === e.d, e.tag, "read byte", int'(g), int'(e.d));
      end
    end
  end

  // serial master
  logic [7:0] tx[$];
  int hdr = 0, n_emit = 0, hold_bit = -1, hold_kind = 0, abort_bit = -1;
  bit oe_any [16];

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic garbage();
    repeat (3) begin
      si = ~si; sck = 1'b1; wait_clk(H);
      sck = 1'b0; wait_clk(H);
    end
  endtask

  task automatic low_hold();
    hold_n = 1'b0; wait_clk(6);
    check(so_oe == 1'b0, "R9", "so_oe while paused", int'(so_oe), 0);
    garbage();
    hold_n = 1'b1; wait_clk(H);
  endtask

  task automatic high_hold();
    wait_clk(4); hold_n = 1'b0; wait_clk(H - 4);
    check(so_oe == 1'b1, "R12", "so_oe before next fall", int'(so_oe), 1);
    sck = 1'b0; wait_clk(6);
    check(so_oe == 1'b0, "R12", "so_oe after fall", int'(so_oe), 0);
    garbage();
    hold_n = 1'b1; wait_clk(H);
  endtask

  task automatic xfer();
    int bi;
    bit stop;
    logic [7:0] rb;
    for (int k = 0; k < 16; k++) oe_any[k] = 1'b0;
    bi = 0; stop = 1'b0;
    cs_n = 1'b0; wait_clk(H);
    for (int i = 0; i < tx.size() && !stop; i++) begin
      rb = 'x;
      for (int b = 7; b >= 0; b--) begin
        if (bi == abort_bit) begin
          cs_n = 1'b1; wait_clk(6);
          check(so_oe == 1'b0, "R8", "so_oe after select rise", int'(so_oe), 0);
          stop = 1'b1;
          break;
        end
        if (bi == hold_bit && hold_kind == 1) low_hold();
        if (bi == hold_bit && hold_kind == 3) hold_n = 1'b0;
        si = tx[i][b]; wait_clk(H);
        rb[b] = (so_oe === 1'b1) ? so : 1'bx;
        if (so_oe === 1'b1) oe_any[i] = 1'b1;
        sck = 1'b1;
        if (bi == hold_bit && hold_kind == 2) high_hold();
        else begin wait_clk(H); sck = 1'b0; end
        bi++;
      end
      if (!stop && i >= hdr && i < hdr + n_emit) got_rd.push_back(rb);
    end
    wait_clk(H); cs_n = 1'b1; hold_n = 1'b1; si = 1'b0; wait_clk(4 * H);
    hold_bit = -1; hold_kind = 0; abort_bit = -1; n_emit = 0;
  endtask

  task automatic set_mode(logic [7:0] v);
    tx = '{8'h01, v}; hdr = 2; xfer();
  endtask

  task automatic read_status(logic [7:0] e, string tag);
    tx = '{8'h05, 8'h00}; hdr = 1; n_emit = 1; push_rd(e, tag); xfer();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    check(so_oe == 1'b0, "R1", "so_oe after reset", int'(so_oe), 0);
    read_status(8'h02, "R1 R7 reset setup byte");

    // single-byte write, upper address bits ignored, extra byte dropped
    push_wr(16'h0123, 8'hA5, "R3 R2 word write");
    tx = '{8'h02, 8'hE1, 8'h23, 8'hA5, 8'h5A}; hdr = 3; xfer();
    check(oe_any[4] == 1'b0, "R4", "so_oe on extra write byte", int'(oe_any[4]), 0);

    push_rd(ref_rd(16'h0123), "R2 word read");
    tx = '{8'h03, 8'h01, 8'h23, 8'h00, 8'h00}; hdr = 3; n_emit = 1; xfer();
    check(oe_any[4] == 1'b0, "R4", "so_oe on extra read byte", int'(oe_any[4]), 0);

    // page mode
    set_mode(8'h80);
    read_status(8'h82, "R7 page setup byte");
    push_wr(16'h003E, 8'h11, "R5"); push_wr(16'h003F, 8'h22, "R5");
    push_wr(16'h0020, 8'h33, "R5 page wrap"); push_wr(16'h0021, 8'h44, "R5");
    tx = '{8'h02, 8'h00, 8'h3E, 8'h11, 8'h22, 8'h33, 8'h44}; hdr = 3; xfer();
    push_rd(ref_rd(16'h003F), "R5"); push_rd(ref_rd(16'h0020), "R5 page wrap read");
    push_rd(ref_rd(16'h0021), "R5");
    tx = '{8'h03, 8'h00, 8'h3F, 8'h00, 8'h00, 8'h00}; hdr = 3; n_emit = 3; xfer();

    // linear mode
    set_mode(8'h40);
    read_status(8'h42, "R7 linear setup byte");
    push_wr(16'h1FFE, 8'h66, "R6"); push_wr(16'h1FFF, 8'h77, "R6");
    push_wr(16'h0000, 8'h88, "R6 top wrap");
    tx = '{8'h02, 8'h1F, 8'hFE, 8'h66, 8'h77, 8'h88}; hdr = 3; xfer();
    push_rd(ref_rd(16'h1FFF), "R6"); push_rd(ref_rd(16'h0000), "R6 top wrap read");
    push_rd(ref_rd(16'h0001), "R6");
    tx = '{8'h03, 8'h1F, 8'hFF, 8'h00, 8'h00, 8'h00}; hdr = 3; n_emit = 3; xfer();
    push_rd(ref_rd(16'h001F), "R6"); push_rd(ref_rd(16'h0020), "R6 page crossing");
    tx = '{8'h03, 8'h00, 8'h1F, 8'h00, 8'h00}; hdr = 3; n_emit = 2; xfer();

    // unknown command
    tx = '{8'h07, 8'h02, 8'h00, 8'h10, 8'hAB, 8'hCD}; hdr = 6; xfer();
    for (int k = 0; k < 6; k++)
      check(oe_any[k] == 1'b0, "R11", "so_oe after unknown command", int'(oe_any[k]), 0);

    // pause during low phase (read and write), and during high phase
    push_rd(ref_rd(16'h003E), "R9"); push_rd(ref_rd(16'h003F), "R9 resumed byte");
    push_rd(ref_rd(16'h0040), "R9");
    tx = '{8'h03, 8'h00, 8'h3E, 8'h00, 8'h00, 8'h00}; hdr = 3; n_emit = 3;
    hold_bit = 35; hold_kind = 1; xfer();
    push_rd(ref_rd(16'h003E), "R12 paused byte"); push_rd(ref_rd(16'h003F), "R12");
    tx = '{8'h03, 8'h00, 8'h3E, 8'h00, 8'h00}; hdr = 3; n_emit = 2;
    hold_bit = 27; hold_kind = 2; xfer();
    push_wr(16'h0200, 8'hC3, "R9"); push_wr(16'h0201, 8'h3C, "R9 paused write byte");
    tx = '{8'h02, 8'h02, 8'h00, 8'hC3, 8'h3C}; hdr = 3;
    hold_bit = 37; hold_kind = 1; xfer();

    // select rise ends transfers
    push_rd(ref_rd(16'h0200), "R8");
    tx = '{8'h03, 8'h02, 8'h00, 8'h00, 8'h00}; hdr = 3; n_emit = 1;
    abort_bit = 36; xfer();
    push_wr(16'h0300, 8'h5A, "R8");
    tx = '{8'h02, 8'h03, 8'h00, 8'h5A, 8'hA5}; hdr = 3;
    abort_bit = 36; xfer();

    // pause disabled
    set_mode(8'h41);
    read_status(8'h43, "R7 R10 setup byte");
    push_rd(ref_rd(16'h0200), "R10"); push_rd(ref_rd(16'h0201), "R10");
    tx = '{8'h03, 8'h02, 8'h00, 8'h00, 8'h00}; hdr = 3; n_emit = 2;
    hold_bit = 26; hold_kind = 3; xfer();
    check(oe_any[3] == 1'b1 && oe_any[4] == 1'b1, "R10", "so_oe with pause pin low",
          {oe_any[3], oe_any[4]}, 3);

    wait_clk(20);
    check(exp_wr.size() == 0, "R3", "pending expected writes", exp_wr.size(), 0);
    check(exp_rd.size() == 0, "R2", "pending expected reads", exp_rd.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule